// File: doc/BRIEF.md
# Watchdog Timer with Safe Frequency-Select Fallback

This block guards a clock generator's frequency-select path against a system that hangs after being pushed to a frequency it cannot run at. It counts coarse time-base ticks down from a programmable timeout. If software does not restart it in time, it raises an alarm flag and replaces the live select code with a programmed safe code. It also pulls a system reset line low for a fixed number of ticks.

The enable starts from a board strap, which is sampled on the first clock after reset is released. Software can later start or stop the watchdog through a control write. The same control write carries the safe select code. A separate 8-bit timeout register holds the timeout as a number of time units, and each unit lasts `UNIT_TICKS` ticks. Writing the timeout register restarts the count, and so does turning the watchdog on from the off state. Either action also clears the alarm.

The reset output models an open-drain pin. A value of 0 means the pin pulls the line low. A value of 1 means the pin is released and an external pull-up holds the line high.

Top module: `wdt_safe_sel`

## Requirements
- R1: While reset is held and directly after it, `alarm` is 0, `sys_rst_od_n` is 1 and `sel_out` equals `sel_in`. The timeout register holds `DEF_TO` (4 units) and the safe code holds `DEF_SAFE` (4'hE).
- R2: The enable is loaded from `strap_en` on the first clock edge after reset is released. With the strap at 0, no number of ticks raises `alarm`.
- R3: A control write with `ctl_en`=1 starts the watchdog, and one with `ctl_en`=0 stops it. While stopped, ticks are not counted and `alarm` cannot rise. A write that turns the watchdog on from the off state restarts the count from the timeout register and clears `alarm`.
- R4: With timeout T, `alarm` rises on the edge of the T*`UNIT_TICKS`-th tick after the last restart, and T=0 behaves like T=1. Clock cycles with `tick` low do not advance the count.
- R5: A write to the timeout register stores `to_val`, restarts the count from it and clears `alarm` on the next edge.
- R6: `alarm` reads 1 in alarm mode and 0 in normal mode. Once set, it stays set until a restart, even if the watchdog is stopped.
- R7: While `alarm` is 1, `sel_out` equals the stored safe code and ignores changes on `sel_in`. While `alarm` is 0, `sel_out` follows `sel_in` in the same cycle. A new safe code takes effect on the next edge even during alarm. A control write with `ctl_en`=1 while the watchdog is already on does not restart the count.
- R8: On the edge where `alarm` rises, `sys_rst_od_n` goes to 0. It stays at 0 through `PULSE_TICKS`-1 further ticks and returns to 1 on the edge of the `PULSE_TICKS`-th tick.
- R9: While `alarm` stays set, no further reset pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle time-base tick |
| strap_en | input | 1 | Power-up strap that supplies the initial enable |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_en | input | 1 | Enable bit of the control write |
| ctl_safe | input | SEL_W | Safe select code of the control write |
| to_wr | input | 1 | Timeout register write strobe |
| to_val | input | TO_W | Timeout, in time units |
| sel_in | input | SEL_W | Select code chosen by hardware or software |
| sel_out | output | SEL_W | Select code in effect |
| alarm | output | 1 | Alarm status: 1 means alarm, 0 means normal |
| sys_rst_od_n | output | 1 | Open-drain reset: 0 pulls the line low, 1 releases it |

## Verification
The bench builds the block with `UNIT_TICKS`=3 and `PULSE_TICKS`=5, keeping the default timeout of 4 units and the default safe code 4'hE. At these values a full default timeout takes 12 ticks and a reset pulse takes 5 ticks. Every expiry edge, including the T=0 and T=1 boundaries and a 7-unit timeout, can therefore be hit exactly one tick early and one tick on time. The short pulse also leaves room to show that a pulse does not retrigger while the alarm is held.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Watchdog run state: counting toward expiry, or latched in alarm
  typedef enum logic {
    WD_COUNT = 1'b0,
    WD_ALARM = 1'b1
  } wd_state_e;

endpackage

// File: rtl/wdt_cfg.sv
module wdt_cfg #(
  parameter int SEL_W    = 4,
  parameter int TO_W     = 8,
  parameter int DEF_TO   = 4,
  parameter int DEF_SAFE = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap_en,
  input  logic             ctl_wr,
  input  logic             ctl_en,
  input  logic [SEL_W-1:0] ctl_safe,
  input  logic             to_wr,
  input  logic [TO_W-1:0]  to_val,
  output logic             en_q,
  output logic [SEL_W-1:0] safe_q,
  output logic [TO_W-1:0]  to_q,
  output logic             reload
);

  logic             booted_q, booted_d;
  logic             en_d;
  logic [SEL_W-1:0] safe_d;
  logic [TO_W-1:0]  to_d;

  always_comb begin
    booted_d = booted_q;
    en_d     = en_q;
    safe_d   = safe_q;
    to_d     = to_q;
    reload   = 1'b0;
    if (!booted_q) begin
      // first edge after reset: take the enable from the strap
      booted_d = 1'b1;
      en_d     = strap_en;
      reload   = 1'b1;
    end else if (ctl_wr) begin
      en_d   = ctl_en;
      safe_d = ctl_safe;
      if (ctl_en && !en_q) reload = 1'b1;
    end
    if (to_wr) begin
      to_d   = to_val;
      reload = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      booted_q <= 1'b0;
      en_q     <= 1'b0;
      safe_q   <= SEL_W'(DEF_SAFE);
      to_q     <= TO_W'(DEF_TO);
    end else begin
      booted_q <= booted_d;
      en_q     <= en_d;
      safe_q   <= safe_d;
      to_q     <= to_d;
    end
  end

endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int UNIT_TICKS = 580
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  input  logic tick,
  output logic unit_end
);

  localparam int PW = (UNIT_TICKS > 1) ? $clog2(UNIT_TICKS) : 1;
  localparam logic [PW-1:0] LAST = PW'(UNIT_TICKS - 1);

  logic [PW-1:0] pcnt_q, pcnt_d;

  assign unit_end = run && tick && !clr && (pcnt_q == LAST);

  always_comb begin
    pcnt_d = pcnt_q;
    if (clr)           pcnt_d = '0;
    else if (unit_end) pcnt_d = '0;
    else if (run && tick) pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

endmodule

// File: rtl/wdt_down.sv
module wdt_down #(
  parameter int TO_W   = 8,
  parameter int DEF_TO = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reload,
  input  logic [TO_W-1:0] load_val,
  input  logic            unit_end,
  output logic            alarm,
  output logic            expire
);

  import wdt_pkg::*;

  wd_state_e       st_q, st_d;
  logic [TO_W-1:0] units_q, units_d;

  assign alarm = (st_q == WD_ALARM);

  always_comb begin
    st_d    = st_q;
    units_d = units_q;
    expire  = 1'b0;
    if (reload) begin
      st_d    = WD_COUNT;
      units_d = load_val;
    end else if (unit_end && st_q == WD_COUNT) begin
      if (units_q <= TO_W'(1)) begin
        st_d    = WD_ALARM;
        units_d = '0;
        expire  = 1'b1;
      end else begin
        units_d = units_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= WD_COUNT;
      units_q <= TO_W'(DEF_TO);
    end else begin
      st_q    <= st_d;
      units_q <= units_d;
    end
  end

endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int PULSE_TICKS = 288
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic tick,
  output logic pull_low
);

  localparam int CW = $clog2(PULSE_TICKS + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign pull_low = (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (fire)                  cnt_d = CW'(PULSE_TICKS);
    else if (tick && pull_low) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/wdt_safe_sel.sv
module wdt_safe_sel #(
  parameter int SEL_W       = 4,
  parameter int TO_W        = 8,
  parameter int UNIT_TICKS  = 580,
  parameter int PULSE_TICKS = 288,
  parameter int DEF_TO      = 4,
  parameter int DEF_SAFE    = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             strap_en,
  input  logic             ctl_wr,
  input  logic             ctl_en,
  input  logic [SEL_W-1:0] ctl_safe,
  input  logic             to_wr,
  input  logic [TO_W-1:0]  to_val,
  input  logic [SEL_W-1:0] sel_in,
  output logic [SEL_W-1:0] sel_out,
  output logic             alarm,
  output logic             sys_rst_od_n
);

  logic             en_q;
  logic [SEL_W-1:0] safe_q;
  logic [TO_W-1:0]  to_q;
  logic             reload;
  logic             unit_end;
  logic             expire;
  logic             pull_low;

  wdt_cfg #(
    .SEL_W(SEL_W), .TO_W(TO_W), .DEF_TO(DEF_TO), .DEF_SAFE(DEF_SAFE)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .strap_en(strap_en),
    .ctl_wr(ctl_wr), .ctl_en(ctl_en), .ctl_safe(ctl_safe),
    .to_wr(to_wr), .to_val(to_val),
    .en_q(en_q), .safe_q(safe_q), .to_q(to_q), .reload(reload)
  );

  wdt_prescale #(.UNIT_TICKS(UNIT_TICKS)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(en_q && !alarm), .clr(reload),
    .tick(tick), .unit_end(unit_end)
  );

  wdt_down #(.TO_W(TO_W), .DEF_TO(DEF_TO)) u_down (
    .clk(clk), .rst_n(rst_n), .reload(reload),
    .load_val(reload && to_wr ? to_val : to_q),
    .unit_end(unit_end), .alarm(alarm), .expire(expire)
  );

  wdt_pulse #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(expire), .tick(tick),
    .pull_low(pull_low)
  );

  assign sel_out      = alarm ? safe_q : sel_in;
  assign sys_rst_od_n = !pull_low;

endmodule

// File: rtl/wdt_safe_sel_chk.sv
module wdt_safe_sel_chk #(
  parameter int SEL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_wr,
  input logic             to_wr,
  input logic             en_q,
  input logic [SEL_W-1:0] sel_out,
  input logic             alarm,
  input logic             sys_rst_od_n
);

  // R5: timeout write always leaves the next cycle in normal mode
  assert_to_wr_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    to_wr |=> !alarm);

  // R3: a stopped watchdog cannot enter alarm
  assert_stopped_no_alarm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !alarm) |=> !alarm);

  // R3: switching on from off lands in normal mode
  assert_enable_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> !alarm);

  // R7: held alarm with no control write keeps the select code frozen
  assert_safe_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm && $past(alarm) && !$past(ctl_wr)) |-> $stable(sel_out));

  // R8: the reset line is pulled low on the edge the alarm sets
  assert_pulse_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm) |-> !sys_rst_od_n);

  // R9: the line only falls together with a fresh alarm
  assert_no_retrigger_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_od_n) |-> $rose(alarm));

endmodule

bind wdt_safe_sel wdt_safe_sel_chk #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .to_wr(to_wr), .en_q(en_q),
  .sel_out(sel_out), .alarm(alarm), .sys_rst_od_n(sys_rst_od_n)
);

// File: tb/wdt_safe_sel_test.sv
module wdt_safe_sel_test;

  localparam int SEL_W = 4;
  localparam int TO_W  = 8;

  logic             clk = 1'b0;
  logic             rst_n, tick, strap_en, ctl_wr, ctl_en, to_wr;
  logic [SEL_W-1:0] ctl_safe, sel_in, sel_out;
  logic [TO_W-1:0]  to_val;
  logic             alarm, sys_rst_od_n;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  wdt_safe_sel #(
    .SEL_W(SEL_W), .TO_W(TO_W), .UNIT_TICKS(3), .PULSE_TICKS(5),
    .DEF_TO(4), .DEF_SAFE(14)
  ) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .strap_en(strap_en),
    .ctl_wr(ctl_wr), .ctl_en(ctl_en), .ctl_safe(ctl_safe),
    .to_wr(to_wr), .to_val(to_val), .sel_in(sel_in),
    .sel_out(sel_out), .alarm(alarm), .sys_rst_od_n(sys_rst_od_n)
  );

  // {to_val[8], sel_in[4], ticks[8], exp_alarm[1], exp_sel[4]}
  localparam logic [24:0] VEC [8] = '{
    {8'd2, 4'h3, 8'd5,  1'b0, 4'h3},
    {8'd2, 4'h3, 8'd6,  1'b1, 4'h2},
    {8'd1, 4'h5, 8'd2,  1'b0, 4'h5},
    {8'd1, 4'h5, 8'd3,  1'b1, 4'h2},
    {8'd0, 4'h9, 8'd2,  1'b0, 4'h9},
    {8'd0, 4'h9, 8'd3,  1'b1, 4'h2},
    {8'd7, 4'hA, 8'd20, 1'b0, 4'hA},
    {8'd7, 4'hA, 8'd21, 1'b1, 4'h2}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic write_to(input logic [TO_W-1:0] v);
    @(negedge clk) begin to_wr = 1'b1; to_val = v; end
    @(negedge clk) to_wr = 1'b0;
  endtask

  task automatic write_ctl(input logic e, input logic [SEL_W-1:0] s);
    @(negedge clk) begin ctl_wr = 1'b1; ctl_en = e; ctl_safe = s; end
    @(negedge clk) ctl_wr = 1'b0;
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk) begin rst_n = 1'b0; strap_en = strap; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; strap_en = 1'b1; ctl_wr = 1'b0; ctl_en = 1'b0;
    ctl_safe = '0; to_wr = 1'b0; to_val = '0; sel_in = 4'h6;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 alarm", alarm, 0);
    check("R1 rst line", sys_rst_od_n, 1);
    check("R1 sel pass", sel_out, 4'h6);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after release", alarm, 0);

    // R2/R4/R1: strap on, default 4 units of 3 ticks
    ticks(11);
    check("R4 one tick early", alarm, 0);
    ticks(1);
    check("R4 default expiry", alarm, 1);
    check("R1 default safe code", sel_out, 4'hE);
    // R8: pulse width
    check("R8 pulse starts", sys_rst_od_n, 0);
    ticks(4);
    check("R8 still low", sys_rst_od_n, 0);
    ticks(1);
    check("R8 released", sys_rst_od_n, 1);
    // R9: no retrigger while alarm held
    ticks(10);
    check("R9 no retrigger", sys_rst_od_n, 1);
    check("R6 alarm held", alarm, 1);
    // R7: safe code ignores sel_in, new safe code without restart
    sel_in = 4'h3;
    @(negedge clk);
    check("R7 ignores sel_in", sel_out, 4'hE);
    write_ctl(1'b1, 4'h2);
    check("R7 new safe code", sel_out, 4'h2);
    check("R7 no restart", alarm, 1);

    // R5/R4: vector table
    for (int v = 0; v < 8; v++) begin
      write_to(VEC[v][24:17]);
      check("R5 cleared", alarm, 0);
      sel_in = VEC[v][16:13];
      ticks(int'(VEC[v][12:5]));
      check("R4 vec alarm", alarm, 32'(VEC[v][4]));
      check("R7 vec sel", sel_out, 32'(VEC[v][3:0]));
    end

    // R4: clock cycles without tick do not count
    write_to(8'd1);
    repeat (50) @(negedge clk);
    check("R4 no tick no count", alarm, 0);
    sel_in = 4'h7;
    @(negedge clk);
    check("R7 follows sel_in", sel_out, 4'h7);
    ticks(3);
    check("R4 tick count", alarm, 1);

    // R3: stop freezes, restart reloads
    write_to(8'd2);
    ticks(3);
    write_ctl(1'b0, 4'h2);
    ticks(20);
    check("R3 stopped", alarm, 0);
    write_ctl(1'b1, 4'h2);
    ticks(5);
    check("R3 reload on start", alarm, 0);
    ticks(1);
    check("R3 expiry after start", alarm, 1);
    write_ctl(1'b0, 4'h2);
    ticks(5);
    check("R6 alarm kept when stopped", alarm, 1);
    write_ctl(1'b1, 4'h2);
    check("R3 start clears alarm", alarm, 0);

    // R2: strap off keeps watchdog idle
    do_reset(1'b0);
    ticks(30);
    check("R2 strap off", alarm, 0);
    write_ctl(1'b1, 4'hE);
    ticks(11);
    check("R3 sw start early", alarm, 0);
    ticks(1);
    check("R3 sw start expiry", alarm, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule